// File: doc/BRIEF.md
# Microstep Stepper Phase Sequencer

This block turns step pulses into current commands for the two windings of a bipolar stepper motor. It keeps one position on a 32-point electrical circle. Each step moves that position by 8, 4, 2 or 1 points, according to the selected excitation mode. From the position it derives a sign and a magnitude for each winding. The magnitude is given in tenths of a percent of full current. An analog current loop and a power bridge downstream turn these commands into winding current.

Step pulses arrive on two asynchronous inputs, `step_a` and `step_b`. Each input is synchronized to the system clock and then edge-detected. With one pulse source, `step_a` carries the steps and `dir` picks the direction. With two pulse sources, `dir` is held low, `step_a` steps forward and `step_b` steps backward.

An active-low enable turns the windings off and leaves the position counter running. An active-low hold input does three things: it forces the position to home, it blocks stepping and it turns the windings off. The active-low `home_n` monitor goes low at the home position.

Top module: `stepper_phase_seq`

## Requirements
- R1: `mode` = {M2,M1} sets the step stride: 2'b00 full step (stride 8), 2'b01 half step (stride 4), 2'b10 quarter step (stride 2), 2'b11 eighth step (stride 1). The index wraps modulo 32.
- R2: In modes 01/10/11, let q = idx/8 and f = idx%8. Let L = {1000,1000,910,830,710,555,400,200,0} for p = 0..8, with D = L[f] and U = L[8-f]. The windings are then: q0 A=+D, B=+U; q1 A=-U, B=+D; q2 A=-D, B=-U; q3 A=+U, B=-D.
- R3: In mode 00 both magnitudes are 1000. The signs (A,B) are (+,-) in q0, (+,+) in q1, (-,+) in q2 and (-,-) in q3.
- R4: A sign bit of 1 means negative current. The sign bit is 0 whenever the magnitude of that winding is 0.
- R5: `home_n` is low exactly when the index is 0 or hold is active. Index 0 is A=+1000 with B=0 in the microstep modes, and A=+1000 with B=-1000 in full step.
- R6: A rising edge on `step_a` steps forward when `dir`=0 and backward when `dir`=1. A rising edge on `step_b` does the opposite. Rising edges on both inputs in the same cycle cancel each other.
- R7: While `en_n` is high, `a_off` and `b_off` are high. Steps still move the index, and the magnitude outputs keep following it.
- R8: While `hold_n` is low, both off flags are high, `home_n` is low, the index is forced to 0 and step edges are ignored. After release, stepping starts from home.
- R9: A mode change takes effect on the next step and does not realign the index. A switch away from home can therefore land on off-grid positions.
- R10: A step input held high gives exactly one step. Each step is complete within 3 clock cycles of the input rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hold_n | input | 1 | Active-low hold: forces home, blocks stepping, turns the windings off |
| en_n | input | 1 | Active-low output enable |
| step_a | input | 1 | Step pulse input A (asynchronous) |
| step_b | input | 1 | Step pulse input B (asynchronous) |
| dir | input | 1 | Direction select for the step inputs |
| mode | input | 2 | Excitation mode {M2,M1} |
| a_neg | output | 1 | Winding A sign (1 = negative) |
| a_mag | output | 10 | Winding A magnitude, 0.1 % units |
| a_off | output | 1 | Winding A off |
| b_neg | output | 1 | Winding B sign (1 = negative) |
| b_mag | output | 10 | Winding B magnitude, 0.1 % units |
| b_off | output | 1 | Winding B off |
| home_n | output | 1 | Active-low home monitor |

## Verification
A wrong index value shows at the ports as soon as the step that produced it completes. The error appears as a wrong magnitude pair or a wrong sign quadrant within three clocks of the step edge. A wrong index also moves `home_n`, so an off-by-one or a wrong stride is visible after a single pulse. The bench walks every mode more than once around the circle in each direction. After every pulse it compares all outputs against an arithmetic model of the index. This means a dropped edge, a doubled edge or a stale mode is caught on the next comparison.

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq #(
  parameter int MAG_W = 10
) (
  input  logic             clk,
  input  logic             hold_n,
  input  logic             en_n,
  input  logic             step_a,
  input  logic             step_b,
  input  logic             dir,
  input  logic [1:0]       mode,
  output logic             a_neg,
  output logic [MAG_W-1:0] a_mag,
  output logic             a_off,
  output logic             b_neg,
  output logic [MAG_W-1:0] b_mag,
  output logic             b_off,
  output logic             home_n
);
  localparam int IDX_W = 5;
  localparam logic [MAG_W-1:0] FULL = MAG_W'(1000);

  logic [2:0] sa, sb;
  logic       rise_a, rise_b, step_fw, step_rv;
  logic [IDX_W-1:0] idx, stride;
  logic [1:0] quad;
  logic [2:0] fine;
  logic [MAG_W-1:0] dec_lvl, inc_lvl;
  logic       sgn_a, sgn_b;
  logic [MAG_W-1:0] mag_a, mag_b;

  function automatic logic [MAG_W-1:0] lvl(input logic [3:0] p);
    case (p)
      4'd0, 4'd1: lvl = MAG_W'(1000);
      4'd2:       lvl = MAG_W'(910);
      4'd3:       lvl = MAG_W'(830);
      4'd4:       lvl = MAG_W'(710);
      4'd5:       lvl = MAG_W'(555);
      4'd6:       lvl = MAG_W'(400);
      4'd7:       lvl = MAG_W'(200);
      default:    lvl = '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!hold_n) begin
      sa <= '0;
      sb <= '0;
    end else begin
      sa <= {sa[1:0], step_a};
      sb <= {sb[1:0], step_b};
    end
  end

  assign rise_a  = sa[1] & ~sa[2];
  assign rise_b  = sb[1] & ~sb[2];
  assign step_fw = ((rise_a & ~dir) | (rise_b & dir)) & ~((rise_a & dir) | (rise_b & ~dir));
  assign step_rv = ((rise_a & dir) | (rise_b & ~dir)) & ~((rise_a & ~dir) | (rise_b & dir));
  assign stride  = IDX_W'(5'd8 >> mode);

  always_ff @(posedge clk) begin
    if (!hold_n)      idx <= '0;
    else if (step_fw) idx <= idx + stride;
    else if (step_rv) idx <= idx - stride;
  end

  assign quad    = idx[4:3];
  assign fine    = idx[2:0];
  assign dec_lvl = lvl({1'b0, fine});
  assign inc_lvl = lvl(4'd8 - {1'b0, fine});

  always_comb begin
    if (mode == 2'b00) begin
      mag_a = FULL;
      mag_b = FULL;
      sgn_a = quad[1];
      sgn_b = (quad == 2'd0) || (quad == 2'd3);
    end else begin
      case (quad)
        2'd0:    begin mag_a = dec_lvl; mag_b = inc_lvl; sgn_a = 1'b0; sgn_b = 1'b0; end
        2'd1:    begin mag_a = inc_lvl; mag_b = dec_lvl; sgn_a = 1'b1; sgn_b = 1'b0; end
        2'd2:    begin mag_a = dec_lvl; mag_b = inc_lvl; sgn_a = 1'b1; sgn_b = 1'b1; end
        default: begin mag_a = inc_lvl; mag_b = dec_lvl; sgn_a = 1'b0; sgn_b = 1'b1; end
      endcase
    end
  end

  assign a_mag  = mag_a;
  assign b_mag  = mag_b;
  assign a_neg  = sgn_a & (mag_a != '0);
  assign b_neg  = sgn_b & (mag_b != '0);
  assign a_off  = en_n | ~hold_n;
  assign b_off  = en_n | ~hold_n;
  assign home_n = hold_n & (idx != '0);
endmodule

module stepper_phase_seq_chk #(
  parameter int MAG_W = 10
) (
  input logic             clk,
  input logic             hold_n,
  input logic [1:0]       mode,
  input logic             a_neg,
  input logic [MAG_W-1:0] a_mag,
  input logic             a_off,
  input logic             b_neg,
  input logic [MAG_W-1:0] b_mag,
  input logic             b_off,
  input logic             home_n,
  input logic             step_fw,
  input logic             step_rv,
  input logic [4:0]       idx
);
  always @(posedge clk) begin
    if (!hold_n) AST_HOLD_OUTPUTS: assert (a_off && b_off && !home_n); // R8
  end

  AST_RELEASE_AT_HOME: assert property (@(posedge clk) disable iff (!hold_n)
    $rose(hold_n) |-> (!home_n && !a_neg && a_mag == MAG_W'(1000))); // R8
  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (!hold_n)
    !(step_fw || step_rv) |=> $stable(idx)); // R10
  AST_FULL_MAGS: assert property (@(posedge clk) disable iff (!hold_n)
    (mode == 2'b00) |-> (a_mag == MAG_W'(1000) && b_mag == MAG_W'(1000))); // R3
  AST_ZERO_NO_SIGN: assert property (@(posedge clk) disable iff (!hold_n)
    ((a_mag == '0) |-> !a_neg) and ((b_mag == '0) |-> !b_neg)); // R4
  AST_HOME_VECTOR: assert property (@(posedge clk) disable iff (!hold_n)
    !home_n |-> (!a_neg && a_mag == MAG_W'(1000))); // R5
  AST_MICRO_NONZERO: assert property (@(posedge clk) disable iff (!hold_n)
    (mode != 2'b00) |-> (a_mag != '0 || b_mag != '0)); // R2
endmodule

bind stepper_phase_seq stepper_phase_seq_chk #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .hold_n(hold_n), .mode(mode),
  .a_neg(a_neg), .a_mag(a_mag), .a_off(a_off),
  .b_neg(b_neg), .b_mag(b_mag), .b_off(b_off),
  .home_n(home_n), .step_fw(step_fw), .step_rv(step_rv), .idx(idx)
);

// File: tb/tb_stepper_phase_seq.sv
module tb_stepper_phase_seq;
  logic clk = 0;
  logic hold_n, en_n, step_a, step_b, dir;
  logic [1:0] mode;
  logic a_neg, a_off, b_neg, b_off, home_n;
  logic [9:0] a_mag, b_mag;
  int n_chk = 0, n_err = 0;
  int e_idx = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stepper_phase_seq dut (
    .clk(clk), .hold_n(hold_n), .en_n(en_n), .step_a(step_a), .step_b(step_b),
    .dir(dir), .mode(mode), .a_neg(a_neg), .a_mag(a_mag), .a_off(a_off),
    .b_neg(b_neg), .b_mag(b_mag), .b_off(b_off), .home_n(home_n)
  );

  function automatic int lv(int p);
    int t[9] = '{1000, 1000, 910, 830, 710, 555, 400, 200, 0};
    return t[p];
  endfunction

  task automatic chk(string req);
    int q = e_idx / 8, f = e_idx % 8, am, bm;
    bit an, bn, eoff, ehome;
    if (mode == 2'b00) begin
      am = 1000; bm = 1000;
      an = (q >= 2); bn = (q == 0 || q == 3);
    end else begin
      case (q)
        0: begin am = lv(f);     bm = lv(8 - f); an = 0; bn = 0; end
        1: begin am = lv(8 - f); bm = lv(f);     an = 1; bn = 0; end
        2: begin am = lv(f);     bm = lv(8 - f); an = 1; bn = 1; end
        default: begin am = lv(8 - f); bm = lv(f); an = 0; bn = 1; end
      endcase
    end
    if (am == 0) an = 0;
    if (bm == 0) bn = 0;
    eoff = en_n || !hold_n;
    ehome = hold_n && (e_idx != 0);
    n_chk++;
    if (a_neg !== an || a_mag !== 10'(am) || b_neg !== bn || b_mag !== 10'(bm) ||
        a_off !== eoff || b_off !== eoff || home_n !== ehome) begin
      n_err++;
      $display("FAIL %s idx=%0d mode=%0d: got A=%b/%0d B=%b/%0d off=%b%b home_n=%b exp A=%b/%0d B=%b/%0d off=%b home_n=%b",
               req, e_idx, mode, a_neg, a_mag, b_neg, b_mag, a_off, b_off, home_n,
               an, am, bn, bm, eoff, ehome);
    end
  endtask

  // which: 0 = step_a, 1 = step_b, 2 = both
  task automatic pulse(int which, bit d);
    @(negedge clk);
    dir = d;
    if (which != 1) step_a = 1;
    if (which != 0) step_b = 1;
    repeat (4) @(negedge clk);
    step_a = 0; step_b = 0;
    repeat (4) @(negedge clk);
  endtask

  function automatic void move(int s);
    e_idx = (e_idx + 32 + s * (8 >> mode)) % 32;
  endfunction

  task automatic go_home();
    @(negedge clk); hold_n = 0;
    repeat (3) @(negedge clk); hold_n = 1;
    repeat (2) @(negedge clk);
    e_idx = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    hold_n = 0; en_n = 0; step_a = 0; step_b = 0; dir = 0; mode = 2'b01;
    repeat (5) @(negedge clk);
    chk("R8 reset state");
    pulse(0, 0);
    chk("R8 steps ignored in hold");
    @(negedge clk); hold_n = 1;
    repeat (2) @(negedge clk);
    chk("R8 release at home");

    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      go_home();
      chk("R5 home per mode");
      for (int k = 0; k < 34; k++) begin
        pulse(0, 0); move(1);
        chk(m == 0 ? "R1 R3 R5 fwd" : "R1 R2 R4 R5 fwd");
      end
      for (int k = 0; k < 34; k++) begin
        pulse(1, 0); move(-1);
        chk(m == 0 ? "R6 R3 rev step_b" : "R6 R2 R4 rev step_b");
      end
      for (int k = 0; k < 5; k++) begin
        pulse(0, 1); move(-1);
        chk("R6 step_a dir=1");
      end
      for (int k = 0; k < 5; k++) begin
        pulse(1, 1); move(1);
        chk("R6 step_b dir=1");
      end
      pulse(2, 0);
      chk("R6 simultaneous cancel");
    end

    mode = 2'b11; go_home();
    @(negedge clk); dir = 0; step_a = 1;
    repeat (20) @(negedge clk);
    move(1); chk("R10 held high one step");
    step_a = 0; repeat (4) @(negedge clk);
    chk("R10 release no step");

    @(negedge clk); en_n = 1;
    @(negedge clk); chk("R7 disabled");
    for (int k = 0; k < 3; k++) begin
      pulse(0, 0); move(1);
      chk("R7 counter runs while disabled");
    end
    @(negedge clk); en_n = 0;
    @(negedge clk); chk("R7 resume at moved position");

    @(negedge clk); hold_n = 0;
    @(negedge clk); e_idx = 0; chk("R8 hold mid run");
    pulse(1, 0); chk("R8 hold ignores step_b");
    @(negedge clk); hold_n = 1;
    repeat (2) @(negedge clk); chk("R8 restart from home");
    pulse(0, 0); move(1); chk("R8 first step from home");

    go_home();
    for (int k = 0; k < 3; k++) begin pulse(0, 0); move(1); end
    chk("R9 at idx 3 eighth step");
    mode = 2'b00; @(negedge clk);
    chk("R9 mode change no realign");
    pulse(0, 0); move(1); chk("R9 full stride off grid");
    mode = 2'b01; pulse(0, 0); move(1); chk("R9 half stride off grid");
    mode = 2'b10; pulse(0, 1); move(-1); chk("R9 quarter reverse off grid");
    mode = 2'b00; pulse(1, 0); move(-1); chk("R9 full reverse off grid");

    go_home();
    mode = 2'b01; @(negedge clk); chk("R9 switch at home");
    pulse(0, 0); move(1); chk("R9 half step after switch at home");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule